// File: doc/BRIEF.md
# Two-Level Predicated SWAR Lane Array

This block is a small array of processing elements (PEs) that all receive the same broadcast instruction through a valid/ready handshake. Each PE owns a file of 64-bit data registers and a file of two-bit predicate registers. A per-instruction mode flag makes the ALU work either on the full 64-bit word or on two independent 32-bit sub-words.

Predication has two nested levels. An array-wide active vector, one bit per PE, decides whether a PE takes part in an instruction at all. Inside an active PE, a chosen predicate register, optionally inverted, gates each destination sub-word. Compare instructions write one flag per sub-word into a predicate register, so a later instruction can run under that result. An if/else pair runs as two instructions under one predicate register, with the second using the inverted sense.

Top module: `pswar_array`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls, every data register reads zero, predicate registers 1..3 read `00`, `act_mask` is all-ones and `in_ready` is high once `rst` is low.
- R2: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. `commit_pulse` is high for exactly the following cycle, and its effect is visible at the outputs only after the next rising edge.
- R3: With `in_split`=1, ADD, SUB, AND and OR work on each 32-bit sub-word separately. Sub-word 0 is bits [31:0] and sub-word 1 is bits [63:32]. Sums and differences wrap at 32 bits, with no carry or borrow between sub-words.
- R4: With `in_split`=0, the ALU works on the full 64-bit word with full carry, and only bit 0 of the effective predicate gates the whole 64-bit write.
- R5: A destination sub-word whose effective predicate bit is 0 keeps its old value. Predicate bit i belongs to sub-word i.
- R6: A PE whose `act_mask` bit is 0 changes neither its data registers nor its predicate registers, whatever its predicate bits are.
- R7: CMPEQ (op 4) and CMPLT (op 5, unsigned) write one flag per sub-word into predicate register `in_mdst`, and only where the effective predicate bit is 1. In 64-bit mode the single flag goes to both bits. Predicate register 0 always reads `11`, and writes to it are dropped.
- R8: With `in_pinv`=1, the predicate read from register `in_pidx` is inverted before it is used.
- R9: CMOV (op 6) copies sub-word of `srca` to `dst` where the effective predicate bit is 1. CSEL (op 7) writes every sub-word of `dst` with `srca` where the bit is 1 and with `srcb` where it is 0.
- R10: SETACT (op 9) loads `act_mask` from `in_imm[3:0]` regardless of any predicate or active bit. It changes no register and applies from the next instruction.
- R11: LDI (op 8) writes `in_imm` into `dst` under the same sub-word predication. Op codes: ADD 0, SUB 1, AND 2, OR 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_op | input | 4 | Operation code |
| in_split | input | 1 | 1 = two 32-bit sub-words, 0 = one 64-bit word |
| in_dst | input | 3 | Destination data register |
| in_srca | input | 3 | First source register |
| in_srcb | input | 3 | Second source register |
| in_pidx | input | 2 | Predicate register used as gate |
| in_pinv | input | 1 | Invert the predicate |
| in_mdst | input | 2 | Predicate register written by compares |
| in_imm | input | 64 | Immediate for LDI and SETACT |
| commit_pulse | output | 1 | High in the cycle in which an instruction commits |
| act_mask | output | 4 | Current active vector, one bit per PE |
| obs_reg | input | 3 | Data register to observe |
| obs_data | output | 256 | Observed data register of every PE, PE p at [64p+63:64p] |
| obs_midx | input | 2 | Predicate register to observe |
| obs_mask | output | 8 | Observed predicate register of every PE, PE p at [2p+1:2p] |

## Verification
A wrong write enable in a PE shows up on the very next observation of its destination register. The observation ports expose every register combinationally, so one sub-word that changed when it should have held, or held when it should have changed, is visible one edge after commit. A corrupted predicate register stays hidden until some instruction is gated by it, and then appears as whole sub-words that were skipped or written in the wrong places. For that reason the directed sequences read back every register of every PE after each instruction. A stuck active bit shows at `act_mask` at once, and in PE registers only on the next broadcast.

// File: rtl/pswar_pkg.sv
package pswar_pkg;
    localparam int DW    = 64;
    localparam int NSUB  = 2;
    localparam int SW    = DW / NSUB;
    localparam int NPE   = 4;
    localparam int NREG  = 8;
    localparam int NMREG = 4;
    localparam int RW    = $clog2(NREG);
    localparam int MW    = $clog2(NMREG);
    localparam int OPW   = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_AND    = 4'd2,
        OP_OR     = 4'd3,
        OP_CMPEQ  = 4'd4,
        OP_CMPLT  = 4'd5,
        OP_CMOV   = 4'd6,
        OP_CSEL   = 4'd7,
        OP_LDI    = 4'd8,
        OP_SETACT = 4'd9
    } op_e;

    typedef struct packed {
        op_e           op;
        logic          split;
        logic [RW-1:0] dst;
        logic [RW-1:0] srca;
        logic [RW-1:0] srcb;
        logic [MW-1:0] pidx;
        logic          pinv;
        logic [MW-1:0] mdst;
        logic [DW-1:0] imm;
    } instr_t;

    function automatic logic writes_reg(op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_CMOV, OP_CSEL, OP_LDI: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic writes_mask(op_e op);
        return (op == OP_CMPEQ) || (op == OP_CMPLT);
    endfunction
endpackage

// File: rtl/pswar_pred.sv
module pswar_pred
    import pswar_pkg::*;
(
    input  op_e             op,
    input  logic            split,
    input  logic            pinv,
    input  logic            active,
    input  logic [NSUB-1:0] mraw,
    output logic [NSUB-1:0] peff,
    output logic [NSUB-1:0] reg_we,
    output logic [NSUB-1:0] msk_we
);
    logic [NSUB-1:0] flip;

    always_comb begin
        flip   = mraw ^ {NSUB{pinv}};
        peff   = split ? flip : {NSUB{flip[0]}};
        reg_we = '0;
        msk_we = '0;
        if (active && writes_reg(op)) begin
            // select uses the predicate as a chooser, so every sub-word lands
            reg_we = (op == OP_CSEL) ? {NSUB{1'b1}} : peff;
        end
        if (active && writes_mask(op)) begin
            msk_we = peff;
        end
    end
endmodule

// File: rtl/pswar_alu.sv
module pswar_alu
    import pswar_pkg::*;
(
    input  op_e             op,
    input  logic            split,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [DW-1:0]   imm,
    input  logic [NSUB-1:0] sel,
    output logic [DW-1:0]   res,
    output logic [NSUB-1:0] flag
);
    logic [DW-1:0]   res_lane;
    logic [NSUB-1:0] flag_lane;
    logic [DW-1:0]   res_wide;
    logic            flag_wide;

    generate
        for (genvar i = 0; i < NSUB; i++) begin : g_sub
            logic [SW-1:0] sa, sb, si, r;
            logic          f;
            assign sa = a[i*SW +: SW];
            assign sb = b[i*SW +: SW];
            assign si = imm[i*SW +: SW];
            always_comb begin
                case (op)
                    OP_ADD:  r = sa + sb;
                    OP_SUB:  r = sa - sb;
                    OP_AND:  r = sa & sb;
                    OP_OR:   r = sa | sb;
                    OP_CMOV: r = sa;
                    OP_CSEL: r = sel[i] ? sa : sb;
                    OP_LDI:  r = si;
                    default: r = '0;
                endcase
                f = (op == OP_CMPEQ) ? (sa == sb) : (sa < sb);
            end
            assign res_lane[i*SW +: SW] = r;
            assign flag_lane[i]         = f;
        end
    endgenerate

    always_comb begin
        case (op)
            OP_ADD:  res_wide = a + b;
            OP_SUB:  res_wide = a - b;
            OP_AND:  res_wide = a & b;
            OP_OR:   res_wide = a | b;
            OP_CMOV: res_wide = a;
            OP_CSEL: res_wide = sel[0] ? a : b;
            OP_LDI:  res_wide = imm;
            default: res_wide = '0;
        endcase
        flag_wide = (op == OP_CMPEQ) ? (a == b) : (a < b);
    end

    assign res  = split ? res_lane  : res_wide;
    assign flag = split ? flag_lane : {NSUB{flag_wide}};
endmodule

// File: rtl/pswar_pe.sv
module pswar_pe
    import pswar_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ex_valid,
    input  instr_t          ex,
    input  logic            active,
    input  logic [RW-1:0]   obs_reg,
    input  logic [MW-1:0]   obs_midx,
    output logic [DW-1:0]   obs_data,
    output logic [NSUB-1:0] obs_mask
);
    logic [DW-1:0]   rf [NREG];
    logic [NSUB-1:0] mk [1:NMREG-1];
    logic [NSUB-1:0] mraw, peff, reg_we, msk_we, flag;
    logic [DW-1:0]   res;

    // register 0 of the predicate file is the always-true gate
    always_comb begin
        mraw = '1;
        if (ex.pidx != '0) mraw = mk[ex.pidx];
        obs_mask = '1;
        if (obs_midx != '0) obs_mask = mk[obs_midx];
    end
    assign obs_data = rf[obs_reg];

    pswar_pred u_pred (
        .op     (ex.op),
        .split  (ex.split),
        .pinv   (ex.pinv),
        .active (active),
        .mraw   (mraw),
        .peff   (peff),
        .reg_we (reg_we),
        .msk_we (msk_we)
    );

    pswar_alu u_alu (
        .op    (ex.op),
        .split (ex.split),
        .a     (rf[ex.srca]),
        .b     (rf[ex.srcb]),
        .imm   (ex.imm),
        .sel   (peff),
        .res   (res),
        .flag  (flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) rf[r] <= '0;
            for (int m = 1; m < NMREG; m++) mk[m] <= '0;
        end else if (ex_valid) begin
            for (int i = 0; i < NSUB; i++) begin
                if (reg_we[i]) rf[ex.dst][i*SW +: SW] <= res[i*SW +: SW];
                if (msk_we[i] && ex.mdst != '0) mk[ex.mdst][i] <= flag[i];
            end
        end
    end

    AST_IDLE_PE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !active) |=> rf[$past(ex.dst)] == $past(rf[ex.dst])) // R6
        else $error("inactive PE changed a register");

    AST_CLEAR_BIT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && active && writes_reg(ex.op) && ex.op != OP_CSEL && !peff[0])
        |=> rf[$past(ex.dst)][SW-1:0] == $past(rf[ex.dst][SW-1:0])) // R5
        else $error("gated sub-word was overwritten");

    AST_FLAG_LANDS: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && active && writes_mask(ex.op) && ex.mdst != '0 && peff[0])
        |=> mk[$past(ex.mdst)][0] == $past(flag[0])) // R7
        else $error("compare flag not stored");
endmodule

// File: rtl/pswar_array.sv
module pswar_array
    import pswar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [OPW-1:0]        in_op,
    input  logic                  in_split,
    input  logic [RW-1:0]         in_dst,
    input  logic [RW-1:0]         in_srca,
    input  logic [RW-1:0]         in_srcb,
    input  logic [MW-1:0]         in_pidx,
    input  logic                  in_pinv,
    input  logic [MW-1:0]         in_mdst,
    input  logic [DW-1:0]         in_imm,
    output logic                  commit_pulse,
    output logic [NPE-1:0]        act_mask,
    input  logic [RW-1:0]         obs_reg,
    output logic [NPE*DW-1:0]     obs_data,
    input  logic [MW-1:0]         obs_midx,
    output logic [NPE*NSUB-1:0]   obs_mask
);
    instr_t         ex_q;
    logic           ex_v;
    logic [NPE-1:0] act_q;
    logic           take;

    assign in_ready     = ~rst;
    assign take         = in_valid && in_ready;
    assign commit_pulse = ex_v;
    assign act_mask     = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_v  <= 1'b0;
            ex_q  <= '0;
            act_q <= '1;
        end else begin
            ex_v <= take;
            if (take) begin
                ex_q.op    <= op_e'(in_op);
                ex_q.split <= in_split;
                ex_q.dst   <= in_dst;
                ex_q.srca  <= in_srca;
                ex_q.srcb  <= in_srcb;
                ex_q.pidx  <= in_pidx;
                ex_q.pinv  <= in_pinv;
                ex_q.mdst  <= in_mdst;
                ex_q.imm   <= in_imm;
            end
            if (ex_v && ex_q.op == OP_SETACT) act_q <= ex_q.imm[NPE-1:0];
        end
    end

    generate
        for (genvar p = 0; p < NPE; p++) begin : g_pe
            pswar_pe u_pe (
                .clk      (clk),
                .rst      (rst),
                .ex_valid (ex_v),
                .ex       (ex_q),
                .active   (act_q[p]),
                .obs_reg  (obs_reg),
                .obs_midx (obs_midx),
                .obs_data (obs_data[p*DW +: DW]),
                .obs_mask (obs_mask[p*NSUB +: NSUB])
            );
        end
    endgenerate

    AST_ACT_LOADS: assert property (@(posedge clk) disable iff (rst)
        (ex_v && ex_q.op == OP_SETACT) |=> act_q == $past(ex_q.imm[NPE-1:0])) // R10
        else $error("active vector not loaded");

    AST_ACT_STEADY: assert property (@(posedge clk) disable iff (rst)
        !(ex_v && ex_q.op == OP_SETACT) |=> $stable(act_q)) // R10
        else $error("active vector moved without SETACT");

    AST_COMMIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |-> $past(in_valid && in_ready)) // R2
        else $error("commit without acceptance");
endmodule

// File: tb/pswar_array_tb.sv
`timescale 1ns/1ps
module pswar_array_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [3:0] in_op = '0;
    logic in_split = 1'b0;
    logic [2:0] in_dst = '0, in_srca = '0, in_srcb = '0;
    logic [1:0] in_pidx = '0, in_mdst = '0;
    logic in_pinv = 1'b0;
    logic [63:0] in_imm = '0;
    logic commit_pulse;
    logic [3:0] act_mask;
    logic [2:0] obs_reg = '0;
    logic [255:0] obs_data;
    logic [1:0] obs_midx = '0;
    logic [7:0] obs_mask;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [63:0] m_rf [4][8];
    logic [1:0]  m_mk [4][4];
    logic [3:0]  m_act;

    always #2 clk = ~clk;

    pswar_array u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_split(in_split), .in_dst(in_dst), .in_srca(in_srca),
        .in_srcb(in_srcb), .in_pidx(in_pidx), .in_pinv(in_pinv), .in_mdst(in_mdst),
        .in_imm(in_imm), .commit_pulse(commit_pulse), .act_mask(act_mask),
        .obs_reg(obs_reg), .obs_data(obs_data), .obs_midx(obs_midx), .obs_mask(obs_mask)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] peek(input int pe, input int r);
        return m_rf[pe][r];
    endfunction

    task automatic read_reg(input int pe, input int r, output logic [63:0] v);
        obs_reg = 3'(r);
        #1;
        v = obs_data[pe*64 +: 64];
    endtask

    task automatic model_exec(input int op, input bit split, input int dst, input int sa,
                              input int sb, input int pidx, input bit pinv, input int mdst,
                              input logic [63:0] imm);
        if (op == 9) begin
            m_act = imm[3:0];
            return;
        end
        for (int pe = 0; pe < 4; pe++) begin
            logic [1:0] p;
            logic [63:0] a, b, r;
            logic [1:0] f;
            if (!m_act[pe]) continue;
            p = (pidx == 0) ? 2'b11 : m_mk[pe][pidx];
            if (pinv) p = ~p;
            if (!split) p = {2{p[0]}};
            a = m_rf[pe][sa];
            b = m_rf[pe][sb];
            if (split) begin
                for (int s = 0; s < 2; s++) begin
                    logic [31:0] x, y, z;
                    x = a[s*32 +: 32];
                    y = b[s*32 +: 32];
                    case (op)
                        0: z = x + y;
                        1: z = x - y;
                        2: z = x & y;
                        3: z = x | y;
                        6: z = x;
                        7: z = p[s] ? x : y;
                        default: z = imm[s*32 +: 32];
                    endcase
                    r[s*32 +: 32] = z;
                    f[s] = (op == 4) ? (x == y) : (x < y);
                end
            end else begin
                case (op)
                    0: r = a + b;
                    1: r = a - b;
                    2: r = a & b;
                    3: r = a | b;
                    6: r = a;
                    7: r = p[0] ? a : b;
                    default: r = imm;
                endcase
                f = {2{(op == 4) ? (a == b) : (a < b)}};
            end
            for (int s = 0; s < 2; s++) begin
                if ((op <= 3 || op == 6 || op == 8) && p[s]) m_rf[pe][dst][s*32 +: 32] = r[s*32 +: 32];
                if (op == 7) m_rf[pe][dst][s*32 +: 32] = r[s*32 +: 32];
                if ((op == 4 || op == 5) && p[s] && mdst != 0) m_mk[pe][mdst][s] = f[s];
            end
        end
    endtask

    task automatic compare_all(input string req);
        for (int pe = 0; pe < 4; pe++) begin
            for (int r = 0; r < 8; r++) begin
                logic [63:0] v;
                read_reg(pe, r, v);
                chk(v === m_rf[pe][r], req, v, m_rf[pe][r]);
            end
            for (int m = 0; m < 4; m++) begin
                obs_midx = 2'(m);
                #1;
                chk(obs_mask[pe*2 +: 2] === ((m == 0) ? 2'b11 : m_mk[pe][m]), req,
                    64'(obs_mask[pe*2 +: 2]), 64'((m == 0) ? 2'b11 : m_mk[pe][m]));
            end
        end
        chk(act_mask === m_act, {req, " R10 act"}, 64'(act_mask), 64'(m_act));
    endtask

    task automatic issue(input int op, input bit split, input int dst, input int sa, input int sb,
                         input int pidx, input bit pinv, input int mdst, input logic [63:0] imm,
                         input string req);
        logic [63:0] old, v;
        @(negedge clk);
        in_op = 4'(op); in_split = split; in_dst = 3'(dst); in_srca = 3'(sa);
        in_srcb = 3'(sb); in_pidx = 2'(pidx); in_pinv = pinv; in_mdst = 2'(mdst);
        in_imm = imm; in_valid = 1'b1;
        old = m_rf[0][dst];
        @(negedge clk);
        in_valid = 1'b0;
        chk(commit_pulse === 1'b1, "R2 pulse", 64'(commit_pulse), 64'd1);
        read_reg(0, dst, v);
        chk(v === old, "R2 not yet committed", v, old);
        model_exec(op, split, dst, sa, sb, pidx, pinv, mdst, imm);
        @(negedge clk);
        chk(commit_pulse === 1'b0, "R2 pulse single", 64'(commit_pulse), 64'd0);
        compare_all(req);
    endtask

    task automatic t_reset();
        for (int pe = 0; pe < 4; pe++) begin
            for (int r = 0; r < 8; r++) m_rf[pe][r] = '0;
            for (int m = 0; m < 4; m++) m_mk[pe][m] = 2'b00;
        end
        m_act = 4'hF;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 ready", 64'(in_ready), 64'd1);
        compare_all("R1 reset");
    endtask

    task automatic t_load();
        for (int pe = 0; pe < 4; pe++) begin
            issue(9, 0, 0, 0, 0, 0, 0, 0, 64'(1 << pe), "R10 one-hot");
            issue(8, 1, 1, 0, 0, 0, 0, 0, {32'h10 + 32'(pe), 32'hFFFF_FFF0 + 32'(pe)}, "R11 ldi r1");
        end
        issue(9, 0, 0, 0, 0, 0, 0, 0, 64'hF, "R10 all on");
        issue(8, 0, 2, 0, 0, 0, 0, 0, {32'h20, 32'h20}, "R11 ldi r2");
        chk(peek(2, 1) === {32'h12, 32'hFFFF_FFF2}, "R11 hand", peek(2, 1), {32'h12, 32'hFFFF_FFF2});
    endtask

    task automatic t_alu();
        logic [63:0] v;
        issue(0, 1, 3, 1, 2, 0, 0, 0, '0, "R3 add32");
        read_reg(0, 3, v);
        chk(v === 64'h0000_0030_0000_0010, "R3 add32 wrap", v, 64'h0000_0030_0000_0010);
        issue(0, 0, 4, 1, 2, 0, 0, 0, '0, "R4 add64");
        read_reg(0, 4, v);
        chk(v === 64'h0000_0031_0000_0010, "R4 carry crosses", v, 64'h0000_0031_0000_0010);
        issue(1, 1, 5, 2, 1, 0, 0, 0, '0, "R3 sub32");
        issue(2, 1, 6, 1, 2, 0, 0, 0, '0, "R3 and");
        issue(3, 1, 7, 1, 2, 0, 0, 0, '0, "R3 or");
        issue(8, 0, 5, 0, 0, 0, 0, 0, '0, "R11 clear");
        issue(8, 0, 6, 0, 0, 0, 0, 0, '0, "R11 clear");
        issue(8, 0, 7, 0, 0, 0, 0, 0, '0, "R11 clear");
    endtask

    task automatic t_cmp();
        issue(5, 1, 0, 1, 2, 0, 0, 1, '0, "R7 cmplt split");
        chk(64'(m_mk[0][1]) === 64'd2, "R7 hand lt", 64'(m_mk[0][1]), 64'd2);
        issue(4, 0, 0, 2, 2, 0, 0, 2, '0, "R7 cmpeq wide");
        issue(4, 1, 0, 1, 1, 0, 0, 0, '0, "R7 mask0 ignored");
        issue(4, 1, 0, 1, 2, 1, 0, 2, '0, "R7 predicated cmp");
        obs_midx = 2'd2;
        #1;
        chk(64'(obs_mask[1:0]) === 64'd1, "R7 hand pred cmp", 64'(obs_mask[1:0]), 64'd1);
    endtask

    task automatic t_pred();
        logic [63:0] v;
        issue(0, 1, 5, 1, 2, 1, 0, 0, '0, "R5 gated add");
        read_reg(0, 5, v);
        chk(v === 64'h0000_0030_0000_0000, "R5 low kept", v, 64'h0000_0030_0000_0000);
        issue(1, 1, 5, 2, 1, 1, 1, 0, '0, "R8 else path");
        read_reg(0, 5, v);
        chk(v === 64'h0000_0030_0000_0030, "R8 inverted", v, 64'h0000_0030_0000_0030);
        issue(0, 0, 6, 1, 2, 1, 0, 0, '0, "R4 wide gated off");
        read_reg(0, 6, v);
        chk(v === 64'd0, "R4 bit0 only", v, 64'd0);
        issue(0, 0, 6, 1, 2, 1, 1, 0, '0, "R4 wide gated on");
        read_reg(0, 6, v);
        chk(v === 64'h0000_0031_0000_0010, "R4 full write", v, 64'h0000_0031_0000_0010);
        issue(8, 1, 4, 0, 0, 1, 0, 0, 64'hAAAA_AAAA_BBBB_BBBB, "R11 gated ldi");
    endtask

    task automatic t_moves();
        logic [63:0] v;
        issue(6, 1, 7, 1, 2, 1, 0, 0, '0, "R9 cmov");
        read_reg(0, 7, v);
        chk(v === 64'h0000_0010_0000_0000, "R9 cmov hand", v, 64'h0000_0010_0000_0000);
        issue(7, 1, 0, 1, 2, 1, 0, 0, '0, "R9 csel");
        read_reg(0, 0, v);
        chk(v === 64'h0000_0010_0000_0020, "R9 csel hand", v, 64'h0000_0010_0000_0020);
        issue(7, 0, 3, 1, 2, 2, 0, 0, '0, "R9 csel wide");
    endtask

    task automatic t_active();
        logic [63:0] v;
        issue(9, 0, 0, 0, 0, 1, 1, 0, 64'h5, "R10 setact");
        chk(64'(act_mask) === 64'h5, "R10 hand", 64'(act_mask), 64'h5);
        issue(0, 1, 0, 1, 1, 0, 0, 0, '0, "R6 partial add");
        read_reg(1, 0, v);
        chk(v === 64'h0000_0011_0000_0020, "R6 PE1 untouched", v, 64'h0000_0011_0000_0020);
        issue(5, 1, 0, 2, 1, 0, 0, 3, '0, "R6 partial cmp");
        obs_midx = 2'd3;
        #1;
        chk(64'(obs_mask[3:2]) === 64'd0, "R6 PE1 mask kept", 64'(obs_mask[3:2]), 64'd0);
        issue(9, 0, 0, 0, 0, 0, 0, 0, 64'hF, "R10 restore");
    endtask

    initial begin
        t_reset();
        t_load();
        t_alu();
        t_cmp();
        t_pred();
        t_moves();
        t_active();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule